// File: doc/BRIEF.md
# Long-word to narrow-bus width adapter

This block sits on the read side of a 36-bit FIFO and turns each long-word into one, two or four sub-words on a read port that is 36, 18 or 9 bits wide. The upstream side is a valid/ready long-word interface. The downstream side is a read-enable port with a data-present flag. It works like a fall-through register: the current sub-word is always on the data output while the data-present flag is high, and a read enable sampled on the rising clock edge moves to the next sub-word.

The bus width and the sub-word order are sampled from two configuration inputs while the synchronous reset is held. After reset they stay frozen until the next reset. In MSB-first order the most significant sub-word leaves first. In LSB-first order the least significant sub-word leaves first. A new long-word is taken from upstream only when the last sub-word of the current one is being read, or when the adapter is empty. Because of this, a long-word cannot be lost or overtaken part way through.

The controller has two states. In `ST_EMPTY` no long-word is held and the upstream ready is high. In `ST_LOADED` a long-word is held and its sub-words are presented in order. The transitions are:

- `ST_EMPTY` to `ST_LOADED` when upstream offers a long-word.
- `ST_LOADED` to itself on a non-final read, on a stall, or on a final read that loads the next offered long-word in the same cycle.
- `ST_LOADED` to `ST_EMPTY` on a final read with no long-word offered.

Top module: `lwa_port_adapter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_valid` is 0 and `up_ready` is 1.
- R2: Width code 0 (full width) presents each long-word unchanged on `rd_data[35:0]` and consumes it with a single read.
- R3: Width code 1 (half width) with order bit 0 (MSB first) presents bits 35:18 and then bits 17:0, each on `rd_data[17:0]` with `rd_data[35:18]` at 0.
- R4: Width code 1 with order bit 1 (LSB first) presents bits 17:0 and then bits 35:18, placed as in R3.
- R5: Width code 2 (quarter width) with order bit 0 presents bits 35:27, 26:18, 17:9 and 8:0 in that order, each on `rd_data[8:0]` with `rd_data[35:9]` at 0.
- R6: Width code 2 with order bit 1 presents bits 8:0, 17:9, 26:18 and 35:27 in that order, placed as in R5.
- R7: `up_ready` is 0 while a long-word is held, except in a cycle where `rd_en` is 1 and the last sub-word is being read.
- R8: When `rd_valid` is 1 and `rd_en` is 0, the next cycle still has `rd_valid` at 1 with `rd_data` unchanged. A `rd_en` while `rd_valid` is 0 consumes nothing. An empty upstream stalls the output without skipping or repeating a sub-word.
- R9: `cfg_width` and `cfg_order` are sampled only while `rst_n` is 0. Changing them after reset has no effect on the output.
- R10: Width code 3 behaves as width code 0.
- R11: A read of the last sub-word while upstream offers a long-word loads that long-word in the same cycle, so `rd_valid` stays 1 with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; every transfer happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while it is 0 |
| cfg_width | input | 2 | Bus width code: 0 full, 1 half, 2 quarter, 3 full |
| cfg_order | input | 1 | Sub-word order: 0 MSB first, 1 LSB first |
| up_data | input | 36 | Long-word offered by upstream |
| up_valid | input | 1 | Upstream has a long-word on `up_data` |
| up_ready | output | 1 | Adapter takes `up_data` on this edge if `up_valid` is 1 |
| rd_en | input | 1 | Downstream read enable; consumes the present sub-word |
| rd_data | output | 36 | Current sub-word, right-aligned, with unused upper bits at 0 |
| rd_valid | output | 1 | A sub-word is present on `rd_data` |

## Verification
Every width code and order combination is driven with long-words whose nine-bit lanes all differ. A sub-word that is swapped, shifted or taken from the wrong lane therefore shows up as a data mismatch, not as a coincidental match. Continuous reads with a continuously valid upstream check for bubbles in the single-cycle handover. Sparse read enables combined with a gapped upstream check for stall stability and index integrity across empty periods. A run that changes the configuration inputs after reset shows whether the settings are really frozen. The reserved width code shows whether it falls back to full width.

// File: rtl/lwa_pkg.sv
package lwa_pkg;

    typedef enum logic [1:0] {
        WID_FULL    = 2'd0,
        WID_HALF    = 2'd1,
        WID_QUARTER = 2'd2,
        WID_RSVD    = 2'd3
    } width_e;

    typedef enum logic {
        ORD_MSB_FIRST = 1'b0,
        ORD_LSB_FIRST = 1'b1
    } order_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } seq_state_e;

    typedef struct packed {
        width_e width;
        order_e order;
    } port_cfg_t;

endpackage

// File: rtl/lwa_cfg_latch.sv
module lwa_cfg_latch
    import lwa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_width_i,
    input  logic       cfg_order_i,
    output port_cfg_t  cfg_o,
    output logic [1:0] shift_o
);

    port_cfg_t cfg_q;

    // Configuration follows the pins only while reset is held (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.width <= width_e'(cfg_width_i);
            cfg_q.order <= order_e'(cfg_order_i);
        end
    end

    // Log2 of the sub-word count; the reserved code maps to full width (R10).
    always_comb begin
        unique case (cfg_q.width)
            WID_HALF:    shift_o = 2'd1;
            WID_QUARTER: shift_o = 2'd2;
            default:     shift_o = 2'd0;
        endcase
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/lwa_seq.sv
module lwa_seq
    import lwa_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid_i,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] last_idx_i,
    output logic             up_ready_o,
    output logic             load_o,
    output logic             rd_valid_o,
    output logic [IDX_W-1:0] idx_o
);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             last_sub;
    logic             final_read;
    logic             advance;

    assign last_sub = (idx_q == last_idx_i);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (up_valid_i) state_d = ST_LOADED;
            end
            ST_LOADED: begin
                if (rd_en_i && last_sub && !up_valid_i) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        final_read = 1'b0;
        advance    = 1'b0;
        up_ready_o = 1'b0;
        rd_valid_o = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                up_ready_o = 1'b1;
            end
            ST_LOADED: begin
                rd_valid_o = 1'b1;
                final_read = rd_en_i && last_sub;
                advance    = rd_en_i && !last_sub;
                up_ready_o = final_read;
            end
            default: up_ready_o = 1'b0;
        endcase
        load_o = up_valid_i && up_ready_o;
    end

    // Sub-word index: restarts on every load, steps on each non-final read.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (load_o)  idx_q <= '0;
        else if (advance) idx_q <= idx_q + 1'b1;
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/lwa_lane_mux.sv
module lwa_lane_mux
    import lwa_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic [LANE_W*LANES-1:0]  word_i,
    input  logic [1:0]               shift_i,
    input  order_e                   order_i,
    input  logic [$clog2(LANES)-1:0] idx_i,
    input  logic [$clog2(LANES)-1:0] last_idx_i,
    output logic [LANE_W*LANES-1:0]  data_o
);

    localparam int IDX_W = $clog2(LANES);

    logic [IDX_W-1:0] sub_sel;
    logic [IDX_W-1:0] base;
    logic [IDX_W:0]   lanes_used;

    always_comb begin
        sub_sel    = (order_i == ORD_MSB_FIRST) ? (last_idx_i - idx_i) : idx_i;
        base       = IDX_W'(sub_sel << (IDX_W - int'(shift_i)));
        lanes_used = (IDX_W+1)'(LANES >> shift_i);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W-1:0] src;
        assign src = base + IDX_W'(l);
        assign data_o[l*LANE_W +: LANE_W] =
            ((IDX_W+1)'(l) < lanes_used) ? word_i[src*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/lwa_port_adapter.sv
module lwa_port_adapter
    import lwa_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              cfg_width,
    input  logic                    cfg_order,
    input  logic [LANE_W*LANES-1:0] up_data,
    input  logic                    up_valid,
    output logic                    up_ready,
    input  logic                    rd_en,
    output logic [LANE_W*LANES-1:0] rd_data,
    output logic                    rd_valid
);

    localparam int LW_W  = LANE_W * LANES;
    localparam int IDX_W = $clog2(LANES);

    port_cfg_t        cfg;
    logic [1:0]       shift;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] idx;
    logic             load;
    logic [LW_W-1:0]  word_q;

    lwa_cfg_latch u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_width_i (cfg_width),
        .cfg_order_i (cfg_order),
        .cfg_o       (cfg),
        .shift_o     (shift)
    );

    assign last_idx = IDX_W'((1 << shift) - 1);

    lwa_seq #(.IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid_i (up_valid),
        .rd_en_i    (rd_en),
        .last_idx_i (last_idx),
        .up_ready_o (up_ready),
        .load_o     (load),
        .rd_valid_o (rd_valid),
        .idx_o      (idx)
    );

    // Holding register for the long-word being split.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= up_data;
    end

    lwa_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
        .word_i     (word_q),
        .shift_i    (shift),
        .order_i    (cfg.order),
        .idx_i      (idx),
        .last_idx_i (last_idx),
        .data_o     (rd_data)
    );

endmodule

// File: rtl/lwa_port_adapter_checker.sv
module lwa_port_adapter_checker #(
    parameter int LW_W = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic            up_valid,
    input logic            up_ready,
    input logic            rd_en,
    input logic [LW_W-1:0] rd_data,
    input logic            rd_valid
);

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_valid && up_ready));

    // R1 / R7: an empty adapter always accepts
    a_r7_empty_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> up_ready);

    a_r7_hold_blocks_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |-> !up_ready);

    a_r8_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

    a_r11_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_en && up_valid && up_ready) |=> rd_valid);

endmodule

bind lwa_port_adapter lwa_port_adapter_checker #(.LW_W(LANE_W*LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_ready (up_ready),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/lwa_port_adapter_test.sv
module lwa_port_adapter_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_order = 1'b0;
    logic [35:0] up_data = '0;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic        rd_en = 1'b0;
    logic [35:0] rd_data;
    logic        rd_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lwa_port_adapter uut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_order(cfg_order),
        .up_data(up_data), .up_valid(up_valid), .up_ready(up_ready),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [35:0] word_of(int i);
        logic [35:0] w;
        for (int j = 0; j < 4; j++) w[j*9 +: 9] = 9'(i*37 + j*71 + 5) ^ 9'(j << 7);
        return w;
    endfunction

    function automatic logic [35:0] expect_sub(logic [35:0] w, logic [1:0] code, logic ord, int k);
        int sel;
        if (code == 2'd1) begin
            sel = ord ? k : 1 - k;
            return {18'b0, w[sel*18 +: 18]};
        end else if (code == 2'd2) begin
            sel = ord ? k : 3 - k;
            return {27'b0, w[sel*9 +: 9]};
        end
        return w;
    endfunction

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reset with one configuration, then run with the pins set to another.
    task automatic run_case(string tag, logic [1:0] code_rst, logic ord_rst,
                            logic [1:0] code_run, logic ord_run,
                            int nwords, int rd_gap, int up_gap, bit check_rate);
        logic [1:0]  eff;
        int          nsub, total, got, sent, cycles;
        bit          stalled;
        logic [35:0] prev;
        rst_n = 1'b0; up_valid = 1'b0; rd_en = 1'b0;
        cfg_width = code_rst; cfg_order = ord_rst;
        repeat (3) @(negedge clk);
        check("R1 rd_valid in reset", 36'(rd_valid), 36'd0);
        check("R1 up_ready in reset", 36'(up_ready), 36'd1);
        rst_n = 1'b1;
        cfg_width = code_run; cfg_order = ord_run;
        eff   = (code_rst == 2'd3) ? 2'd0 : code_rst;
        nsub  = 1 << eff;
        total = nwords * nsub;
        got = 0; sent = 0; cycles = 0; stalled = 1'b0; prev = '0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            up_valid = (sent < nwords) && ((cyc % up_gap) == 0);
            up_data  = (sent < nwords) ? word_of(sent) : '0;
            rd_en    = ((cyc % rd_gap) == 0);
            #1;
            if (stalled) begin
                check({tag, " R8 stall"}, {rd_data[35:1], rd_valid}, {prev[35:1], 1'b1});
            end
            if (rd_valid && rd_en && got < total) begin
                check(tag, rd_data, expect_sub(word_of(got / nsub), eff, ord_rst, got % nsub));
                if ((got % nsub) != nsub - 1)
                    check({tag, " R7 no early pop"}, 36'(up_ready), 36'd0);
                got++;
            end else if (rd_valid) begin
                check({tag, " R7 held"}, 36'(up_ready), 36'd0);
            end
            stalled = rd_valid && !rd_en;
            prev    = rd_data;
            if (up_valid && up_ready) sent++;
            cycles = cyc + 1;
            if (got == total) break;
        end
        check({tag, " all sub-words read"}, 36'(got), 36'(total));
        if (check_rate) check("R11 one sub-word per cycle", 36'(cycles), 36'(total + 1));
        up_valid = 1'b0; rd_en = 1'b1;
        repeat (3) @(negedge clk);
        check({tag, " R8 drained, rd_en ignored"}, 36'(rd_valid), 36'd0);
        rd_en = 1'b0;
    endtask

    task automatic test_full();          run_case("R2 full",            2'd0, 1'b0, 2'd0, 1'b0, 6, 1, 1, 1'b1); endtask
    task automatic test_half_msb();      run_case("R3 half msb-first",  2'd1, 1'b0, 2'd1, 1'b0, 6, 1, 1, 1'b1); endtask
    task automatic test_half_lsb();      run_case("R4 half lsb-first",  2'd1, 1'b1, 2'd1, 1'b1, 6, 2, 1, 1'b0); endtask
    task automatic test_quarter_msb();   run_case("R5 quarter msb",     2'd2, 1'b0, 2'd2, 1'b0, 6, 1, 1, 1'b1); endtask
    task automatic test_quarter_lsb();   run_case("R6 quarter lsb",     2'd2, 1'b1, 2'd2, 1'b1, 6, 1, 3, 1'b0); endtask
    task automatic test_stalls();        run_case("R8 sparse both ends",2'd2, 1'b0, 2'd2, 1'b0, 5, 3, 7, 1'b0); endtask
    task automatic test_cfg_frozen();    run_case("R9 cfg frozen",      2'd1, 1'b0, 2'd2, 1'b1, 5, 2, 3, 1'b0); endtask
    task automatic test_rsvd_width();    run_case("R10 code 3",         2'd3, 1'b1, 2'd1, 1'b0, 4, 1, 2, 1'b0); endtask

    initial begin
        test_full();
        test_half_msb();
        test_half_lsb();
        test_quarter_msb();
        test_quarter_lsb();
        test_stalls();
        test_cfg_frozen();
        test_rsvd_width();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule